// File: doc/BRIEF.md
# Write Permission Gate

The write permission gate sits beside a serial command decoder and decides, for each decoded write request, whether that write may reach its target. The decoder raises a request strobe with a target code and an array address. In the same cycle the gate answers with either a grant or a deny, together with a code that gives the reason for a deny. Four kinds of target exist. Two are nonvolatile: the storage array and a stored wiper setting. Two are volatile: a live wiper register and the status register.

Protection comes in two levels. A high write-protect pin on its own stops only nonvolatile writes. The pin held high together with a nonzero block-lock field stops every write, including live wiper moves. The gate also holds a write-enable latch that the decoder sets and clears with explicit commands. Writes to the array and to any wiper require this latch. With the pin low and the latch set, an array write whose address falls inside the region selected by the block-lock field is still refused.

The pin and the lock field are captured in registers. The answer is a combinational function of those registers, the latch and the current request. The decoder samples the answer while its strobe is high.

Top module: `write_gate`

## Requirements
- R1: While the registered write-protect pin is 1, a request to a nonvolatile target (target code 0 = array, 1 = stored wiper) is denied with reason code 1.
- R2: While the registered pin is 1 and the registered lock field is not 00, a request to a volatile target (code 2 = live wiper, 3 = status register) is denied with reason code 2.
- R3: While the registered pin is 0, it causes no deny. With the pin at 1 and the lock field at 00, volatile targets are still granted.
- R4: A request to target codes 0, 1 or 2 that the pin does not block is denied with reason code 3 while the enable latch is clear. Status register writes (code 3) do not depend on the latch.
- R5: Reset clears the enable latch. A set pulse makes it 1 from the next cycle onward, and a clear pulse makes it 0 from the next cycle onward. When both pulses arrive together, the clear takes effect.
- R6: With the pin at 0 and the latch set, an array write is denied with reason code 4 when its address lies in the locked region. For an 8-bit address, the lock codes select the regions as follows: 00 locks nothing, 01 locks 192..255, 10 locks 128..255 and 11 locks 0..255. Other targets ignore the region.
- R7: The deny reasons rank as 1, then 2, then 3, then 4. Reason code 0 goes with a grant. grant_o and deny_o are never high together, and both are 0 while no request is strobed.
- R8: A change on the pin or on the lock field affects decisions from the cycle after it is sampled, not in the cycle of the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wp_i | input | 1 | Write-protect pin, 1 = protect |
| lock_i | input | 2 | Block-lock field, 00 = nothing locked |
| wel_set_i | input | 1 | Pulse that sets the write-enable latch |
| wel_clr_i | input | 1 | Pulse that clears the write-enable latch |
| req_valid_i | input | 1 | Write request strobe |
| req_target_i | input | 2 | 0 array, 1 stored wiper, 2 live wiper, 3 status |
| req_addr_i | input | 8 | Array address of the request |
| grant_o | output | 1 | Request may proceed |
| deny_o | output | 1 | Request refused |
| reason_o | output | 3 | 0 none, 1 pin/nonvolatile, 2 pin/lock, 3 latch clear, 4 locked region |

## Verification
The hardest cases to reach are those where several deny causes hold at the same moment. Each one must give way to the higher-ranked cause, and a pin change must be seen only one cycle late. The stimulus first sets the enable latch and the lock field. It then raises the pin in the same cycle as a request, so that request must still see the old pin. The next request in the following cycle must see the new pin. A second sequence pulses set and clear together and checks that the latch-dependent targets are refused afterwards, while the status register is still granted.

// File: rtl/wgate_pkg.sv
package wgate_pkg;
  typedef enum logic [1:0] {
    TGT_ARRAY      = 2'd0,
    TGT_WIPER_NV   = 2'd1,
    TGT_WIPER_LIVE = 2'd2,
    TGT_STATUS     = 2'd3
  } tgt_e;

  typedef enum logic [2:0] {
    RSN_NONE     = 3'd0,
    RSN_PIN_NV   = 3'd1,
    RSN_PIN_LOCK = 3'd2,
    RSN_NO_WEL   = 3'd3,
    RSN_REGION   = 3'd4
  } rsn_e;

  function automatic logic tgt_is_nv(tgt_e t);
    return (t == TGT_ARRAY) || (t == TGT_WIPER_NV);
  endfunction

  function automatic logic tgt_needs_wel(tgt_e t);
    return t != TGT_STATUS;
  endfunction
endpackage

// File: rtl/wgate_pin_reg.sv
module wgate_pin_reg #(
  parameter int LOCK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_i,
  input  logic [LOCK_W-1:0] lock_i,
  output logic              wp_q_o,
  output logic [LOCK_W-1:0] lock_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q_o   <= 1'b0;
      lock_q_o <= '0;
    end else begin
      wp_q_o   <= wp_i;
      lock_q_o <= lock_i;
    end
  end
endmodule

// File: rtl/wgate_wel.sv
module wgate_wel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wel_o <= 1'b0;
    else if (clr_i) wel_o <= 1'b0;  // clear has priority
    else if (set_i) wel_o <= 1'b1;
  end
endmodule

// File: rtl/wgate_region.sv
module wgate_region #(
  parameter int ADDR_W = 8,
  parameter int LOCK_W = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LOCK_W-1:0] lock_i,
  output logic              locked_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NCODES = 1 << LOCK_W;

  logic [NCODES-1:0] hit;

  assign hit[0] = 1'b0;

  // code c locks the top DEPTH >> (NCODES-1-c) addresses
  for (genvar c = 1; c < NCODES; c++) begin : g_code
    localparam int SHIFT = NCODES - 1 - c;
    localparam int START = (SHIFT >= ADDR_W) ? DEPTH : DEPTH - (DEPTH >> SHIFT);
    assign hit[c] = (int'(addr_i) >= START);
  end

  assign locked_o = hit[lock_i];
endmodule

// File: rtl/wgate_decide.sv
module wgate_decide
  import wgate_pkg::*;
#(
  parameter int LOCK_W = 2
) (
  input  logic              req_i,
  input  tgt_e              tgt_i,
  input  logic              wp_i,
  input  logic [LOCK_W-1:0] lock_i,
  input  logic              wel_i,
  input  logic              in_region_i,
  output logic              grant_o,
  output logic              deny_o,
  output rsn_e              reason_o
);
  rsn_e rsn;

  always_comb begin
    rsn = RSN_NONE;
    if (wp_i && tgt_is_nv(tgt_i))                 rsn = RSN_PIN_NV;
    else if (wp_i && (lock_i != '0))              rsn = RSN_PIN_LOCK;
    else if (tgt_needs_wel(tgt_i) && !wel_i)      rsn = RSN_NO_WEL;
    else if ((tgt_i == TGT_ARRAY) && in_region_i) rsn = RSN_REGION;
  end

  assign grant_o  = req_i && (rsn == RSN_NONE);
  assign deny_o   = req_i && (rsn != RSN_NONE);
  assign reason_o = req_i ? rsn : RSN_NONE;
endmodule

// File: rtl/write_gate.sv
module write_gate
  import wgate_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LOCK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_i,
  input  logic [LOCK_W-1:0] lock_i,
  input  logic              wel_set_i,
  input  logic              wel_clr_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_target_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              grant_o,
  output logic              deny_o,
  output logic [2:0]        reason_o
);
  logic              wp_q;
  logic [LOCK_W-1:0] lock_q;
  logic              wel_q;
  logic              in_region;
  rsn_e              rsn;
  tgt_e              tgt;

  assign tgt = tgt_e'(req_target_i);

  wgate_pin_reg #(.LOCK_W(LOCK_W)) u_pin (
    .clk_i(clk_i), .rst_ni(rst_ni), .wp_i(wp_i), .lock_i(lock_i),
    .wp_q_o(wp_q), .lock_q_o(lock_q)
  );

  wgate_wel u_wel (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(wel_set_i), .clr_i(wel_clr_i),
    .wel_o(wel_q)
  );

  wgate_region #(.ADDR_W(ADDR_W), .LOCK_W(LOCK_W)) u_region (
    .addr_i(req_addr_i), .lock_i(lock_q), .locked_o(in_region)
  );

  wgate_decide #(.LOCK_W(LOCK_W)) u_decide (
    .req_i(req_valid_i), .tgt_i(tgt), .wp_i(wp_q), .lock_i(lock_q),
    .wel_i(wel_q), .in_region_i(in_region),
    .grant_o(grant_o), .deny_o(deny_o), .reason_o(rsn)
  );

  assign reason_o = rsn;
endmodule

// File: rtl/write_gate_chk.sv
module write_gate_chk #(
  parameter int ADDR_W = 8,
  parameter int LOCK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wp_i,
  input logic [LOCK_W-1:0] lock_i,
  input logic              wel_clr_i,
  input logic              req_valid_i,
  input logic [1:0]        req_target_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              grant_o,
  input logic              deny_o,
  input logic [2:0]        reason_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_PIN_NV_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && req_valid_i && $past(wp_i) && !req_target_i[1]
    |-> deny_o && reason_o == 3'd1); // R1

  AST_PIN_LOCK_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && req_valid_i && $past(wp_i) && ($past(lock_i) != '0)
    |-> !grant_o); // R2

  AST_PIN_LOW_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && req_valid_i && !$past(wp_i) && req_target_i == 2'd3
    |-> grant_o); // R3

  AST_CLR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_i |=> !(req_valid_i && req_target_i != 2'd3 && grant_o)); // R5

  AST_GRANT_DENY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && deny_o) && (grant_o == (req_valid_i && reason_o == 3'd0))); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !grant_o && !deny_o && reason_o == 3'd0); // R7

  AST_REGION_ONLY_ARRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_target_i != 2'd0 |-> reason_o != 3'd4); // R6
endmodule

bind write_gate write_gate_chk #(.ADDR_W(ADDR_W), .LOCK_W(LOCK_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wp_i(wp_i), .lock_i(lock_i),
  .wel_clr_i(wel_clr_i), .req_valid_i(req_valid_i),
  .req_target_i(req_target_i), .req_addr_i(req_addr_i),
  .grant_o(grant_o), .deny_o(deny_o), .reason_o(reason_o)
);

// File: tb/write_gate_bench.sv
module write_gate_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wp = 1'b0;
  logic [1:0] lock = 2'b00;
  logic       wel_set = 1'b0, wel_clr = 1'b0;
  logic       req = 1'b0;
  logic [1:0] tgt = 2'd0;
  logic [7:0] addr = 8'd0;
  logic       grant, deny;
  logic [2:0] reason;

  int checks = 0, errors = 0;
  logic       m_wp = 1'b0, m_wel = 1'b0;
  logic [1:0] m_lock = 2'b00;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  write_gate u_write_gate (
    .clk_i(clk), .rst_ni(rst_n), .wp_i(wp), .lock_i(lock),
    .wel_set_i(wel_set), .wel_clr_i(wel_clr), .req_valid_i(req),
    .req_target_i(tgt), .req_addr_i(addr),
    .grant_o(grant), .deny_o(deny), .reason_o(reason)
  );

  function automatic logic [2:0] model(logic w, logic [1:0] lk, logic e,
                                       logic [1:0] t, logic [7:0] a);
    logic in_reg;
    case (lk)
      2'b01:   in_reg = a >= 8'd192;
      2'b10:   in_reg = a >= 8'd128;
      2'b11:   in_reg = 1'b1;
      default: in_reg = 1'b0;
    endcase
    if (w && t <= 2'd1)             return 3'd1;
    if (w && lk != 2'b00)           return 3'd2;
    if (t != 2'd3 && !e)            return 3'd3;
    if (t == 2'd0 && in_reg)        return 3'd4;
    return 3'd0;
  endfunction

  task automatic fail(string tag, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
  endtask

  // monitor: compare while strobe is high, quiet check otherwise
  always @(negedge clk) begin
    #8;
    if (rst_n) begin
      if (req) begin
        logic [2:0] e;
        string t;
        if (exp_q.size() == 0) begin
          checks++; fail("R7", "unexpected request", 1, 0);
        end else begin
          e = exp_q.pop_front(); t = tag_q.pop_front();
          checks++;
          if (reason !== e) fail(t, "reason", reason, e);
          checks++;
          if (grant !== (e == 3'd0) || deny !== (e != 3'd0))
            fail(t, "grant/deny", {grant, deny}, {e == 3'd0, e != 3'd0});
        end
      end else begin
        checks++;
        if (grant !== 1'b0 || deny !== 1'b0 || reason !== 3'd0)
          fail("R7", "idle outputs", {grant, deny, reason}, 0);
      end
    end
  end

  task automatic do_req(logic [1:0] t, logic [7:0] a, string tag);
    @(negedge clk);
    req = 1'b1; tgt = t; addr = a;
    exp_q.push_back(model(m_wp, m_lock, m_wel, t, a));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic pins(logic w, logic [1:0] lk);
    @(negedge clk);
    req = 1'b0; wp = w; lock = lk;
    @(negedge clk);
    m_wp = w; m_lock = lk;
  endtask

  task automatic wel_pulse(logic s, logic c);
    @(negedge clk);
    req = 1'b0; wel_set = s; wel_clr = c;
    @(negedge clk);
    wel_set = 1'b0; wel_clr = 1'b0;
    if (c) m_wel = 1'b0; else if (s) m_wel = 1'b1;
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++; fail("WDOG", "watchdog expired", 1, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5 reset: latch clear, array and wipers refused, status granted (R4)
    do_req(2'd0, 8'd5, "R5");
    do_req(2'd2, 8'd0, "R4");
    do_req(2'd3, 8'd0, "R4");
    idle();
    wel_pulse(1'b1, 1'b0);
    // R3 pin low, no lock: all targets granted
    do_req(2'd0, 8'd255, "R3");
    do_req(2'd1, 8'd0, "R3");
    do_req(2'd2, 8'd0, "R3");
    // R6 region per lock code
    pins(1'b0, 2'b01);
    do_req(2'd0, 8'd191, "R6");
    do_req(2'd0, 8'd192, "R6");
    do_req(2'd2, 8'd200, "R6");
    pins(1'b0, 2'b10);
    do_req(2'd0, 8'd127, "R6");
    do_req(2'd0, 8'd128, "R6");
    pins(1'b0, 2'b11);
    do_req(2'd0, 8'd0, "R6");
    do_req(2'd1, 8'd0, "R6");
    // R1 pin high, no lock: nonvolatile denied, volatile granted (R3)
    pins(1'b1, 2'b00);
    do_req(2'd0, 8'd10, "R1");
    do_req(2'd1, 8'd10, "R1");
    do_req(2'd2, 8'd10, "R3");
    do_req(2'd3, 8'd10, "R3");
    // R2 pin high plus lock: volatile denied too, R7 ranking
    pins(1'b1, 2'b01);
    do_req(2'd2, 8'd0, "R2");
    do_req(2'd3, 8'd0, "R2");
    do_req(2'd0, 8'd250, "R7");
    // R8: pin drop seen one cycle late
    @(negedge clk);
    wp = 1'b0; req = 1'b1; tgt = 2'd3; addr = 8'd0;
    exp_q.push_back(model(m_wp, m_lock, m_wel, 2'd3, 8'd0)); tag_q.push_back("R8");
    @(negedge clk);
    m_wp = 1'b0;
    exp_q.push_back(model(m_wp, m_lock, m_wel, 2'd3, 8'd0)); tag_q.push_back("R8");
    // R8: pin rise in request cycle still sees old pin
    @(negedge clk);
    wp = 1'b1; tgt = 2'd1;
    exp_q.push_back(model(m_wp, m_lock, m_wel, 2'd1, 8'd0)); tag_q.push_back("R8");
    @(negedge clk);
    m_wp = 1'b1;
    exp_q.push_back(model(m_wp, m_lock, m_wel, 2'd1, 8'd0)); tag_q.push_back("R8");
    idle();
    // R5 set and clear together: clear wins
    pins(1'b0, 2'b00);
    wel_pulse(1'b1, 1'b1);
    do_req(2'd0, 8'd1, "R5");
    do_req(2'd1, 8'd1, "R5");
    do_req(2'd3, 8'd1, "R4");
    wel_pulse(1'b1, 1'b0);
    do_req(2'd1, 8'd1, "R5");
    wel_pulse(1'b0, 1'b1);
    do_req(2'd2, 8'd1, "R5");
    // R7 latch clear outranks region
    pins(1'b0, 2'b11);
    do_req(2'd0, 8'd50, "R7");
    idle();
    repeat (2) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fail("R7", "unconsumed expectations", exp_q.size(), 0);
    end
    finish_up();
  end
endmodule